// File: doc/BRIEF.md
# Collision Backoff Retransmit Scheduler

This block decides when a single outgoing frame may be put on a shared line. A frame is accepted with its buffer length and its current retransmission mask. Before every attempt the mask grows. An attempt that ends in a pure collision is retried after a pseudo-random delay, counted in timer ticks and bounded by the mask. Any other outcome completes the frame with a completion code and a one-cycle done pulse.

After every completed frame, the scheduler holds the line quiet for a fixed gap before the next attempt. This gives slow half-duplex receivers time to recover. The tick strobe is an input, and a free-running counter supplies the random bits. The word movement, the line encoding and the CRC belong to neighbouring logic. While the transmit enable is high, that logic begins sending once more than ten words are queued or the end-of-frame flag is raised.

The updated mask is presented on `maskOut` so that the owner of the descriptor can write it back.

Top module: `tx_retry_sched`

## Requirements
- R1: After reset, txEnable, donePulse, complCode and maskOut are all zero, and a start request is accepted at once.
- R2: A frame whose frameLen is zero completes without txEnable ever rising, with code 0x6800.
- R3: Before each attempt the held mask becomes (mask << 1) | 1, and this value is visible on maskOut while txEnable is high.
- R4: The frame aborts with code 0x6400 when bit 15 of the held mask is already set at the moment an attempt is about to begin. In that case txEnable stays low and maskOut keeps its previous value. This holds both for an initial mask and for a mask grown by earlier collisions.
- R5: Only the status bits 0x4000 (underrun), 0x1000 (collision), 0x0400 (data fault) and 0x0200 (parity) are examined when txStatusValid arrives. If none of them is set, the code is 0x4000, whatever the other bits hold.
- R6: If any examined bit is set and the examined bits are not exactly 0x1000, the code is 0x7000 | (examined bits >> 8).
- R7: Examined bits equal to 0x1000 cause a retry. The random value is ((freeClock >> 2) ^ CHAN_ID) & (maskOut >> 1), using the mask of the attempt that collided. A random value of zero starts the next attempt without waiting for any tick.
- R8: With a nonzero random value r, let t = 6·r. The wait runs t mod 128 ticks, then (t div 128) periods of 127 ticks each. txEnable rises two clocks after the tick that ends the wait.
- R9: After every completion, 78 ticks must pass before the next attempt. A start request made during this gap is held and served when the gap ends.
- R10: txStatusValid is ignored unless txEnable is high. A start request is ignored while a frame is being checked, sent or backed off.
- R11: donePulse is high for exactly one clock per frame, and complCode holds its value until the next completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Request to schedule a frame; frameLen and initMask are sampled with it |
| frameLen | input | LEN_W | Buffer length in words |
| initMask | input | 16 | Retransmission mask stored in the descriptor |
| txStatus | input | 16 | Line status at end of an attempt |
| txStatusValid | input | 1 | One-cycle strobe qualifying txStatus |
| freeClock | input | 16 | Free-running counter used as random source |
| tickStb | input | 1 | One-cycle timer tick strobe |
| txEnable | output | 1 | Transmitter enabled for the current attempt |
| maskOut | output | 16 | Current retransmission mask, for write-back |
| complCode | output | 16 | Completion code of the last finished frame |
| donePulse | output | 1 | One-cycle frame completion strobe |

## Verification
The main function is exercised with status words that separate the outcomes. A word holding only bits outside the examined set must give success. Underrun with parity, and collision with fault, must give the error code carrying the shifted bits. A bare collision must retry. Collision retries are driven with freeClock and mask pairs chosen to give a zero random value (an immediate retry), a small value that fits one timer period, and a large value that needs a remainder plus a full 127-tick period. The large case separates the chunked wait from a plain 6·r count. Overflow is reached both from a preset top bit and from a mask grown by a collision. Gap enforcement is probed one tick short of and exactly at 78 ticks, with a start request queued during the gap.

// File: rtl/txsched_pkg.sv
package txsched_pkg;

  localparam int WORD_W = 16;

  // examined line status bits
  localparam logic [WORD_W-1:0] ST_UNDERRUN = 16'h4000;
  localparam logic [WORD_W-1:0] ST_COLLIDE  = 16'h1000;
  localparam logic [WORD_W-1:0] ST_FAULT    = 16'h0400;
  localparam logic [WORD_W-1:0] ST_PARITY   = 16'h0200;
  localparam logic [WORD_W-1:0] ST_WATCHED  =
    ST_UNDERRUN | ST_COLLIDE | ST_FAULT | ST_PARITY;

  // completion codes
  localparam logic [WORD_W-1:0] CODE_GOOD    = 16'h4000;
  localparam logic [WORD_W-1:0] CODE_HWERR   = 16'h7000;
  localparam logic [WORD_W-1:0] CODE_EMPTY   = 16'h6800;
  localparam logic [WORD_W-1:0] CODE_MASKOVF = 16'h6400;

  typedef enum logic [2:0] {
    S_IDLE, S_CHECK, S_TX, S_WAIT, S_GAP
  } schedState_t;

  typedef enum logic [1:0] {
    C_STATUS, C_EMPTY, C_MASKOVF
  } codeSel_t;

  // strobes from control to datapath
  typedef struct packed {
    logic     loadDesc;
    logic     growMask;
    logic     setCode;
    codeSel_t codeSel;
    logic     loadBackoff;
    logic     loadGap;
    logic     reloadPeriod;
  } dpCtl_t;

endpackage

// File: rtl/tx_sched_dp.sv
module tx_sched_dp
  import txsched_pkg::*;
#(
  parameter int LEN_W     = 16,
  parameter int CHAN_ID   = 5,
  parameter int TIMER_W   = 7,
  parameter int TICK_MULT = 6,
  parameter int GAP_TICKS = 78
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [LEN_W-1:0]  frameLen,
  input  logic [WORD_W-1:0] initMask,
  input  logic [WORD_W-1:0] txStatus,
  input  logic [WORD_W-1:0] freeClock,
  input  logic              tickStb,
  output logic              lenZero,
  output logic              maskTop,
  output logic              collOnly,
  output logic              rndZero,
  output logic              timerZero,
  output logic              periodsZero,
  output logic [WORD_W-1:0] maskOut,
  output logic [WORD_W-1:0] complCode,
  output logic              donePulse
);

  localparam int TOTAL_W  = WORD_W + $clog2(TICK_MULT + 1);
  localparam int PERIOD_W = TOTAL_W - TIMER_W;
  localparam logic [WORD_W-1:0] CHAN_VAL = WORD_W'(CHAN_ID);

  logic [WORD_W-1:0]   maskQ;
  logic                emptyQ;
  logic [WORD_W-1:0]   codeQ;
  logic                doneQ;
  logic [TIMER_W-1:0]  timerQ;
  logic [PERIOD_W-1:0] periodsQ;

  logic [WORD_W-1:0]   watched;
  logic [WORD_W-1:0]   rnd;
  logic [TOTAL_W-1:0]  totalTicks;
  logic [WORD_W-1:0]   statusCode;

  assign watched    = txStatus & ST_WATCHED;
  assign collOnly   = (watched == ST_COLLIDE);
  assign rnd        = ((freeClock >> 2) ^ CHAN_VAL) & (maskQ >> 1);
  assign rndZero    = (rnd == '0);
  assign totalTicks = TOTAL_W'(rnd) * TOTAL_W'(TICK_MULT);
  assign statusCode = (watched == '0) ? CODE_GOOD
                                      : (CODE_HWERR | (watched >> 8));

  assign lenZero     = emptyQ;
  assign maskTop     = maskQ[WORD_W-1];
  assign timerZero   = (timerQ == '0);
  assign periodsZero = (periodsQ == '0);
  assign maskOut     = maskQ;
  assign complCode   = codeQ;
  assign donePulse   = doneQ;

  // descriptor state
  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskQ  <= '0;
      emptyQ <= 1'b0;
    end else if (ctl.loadDesc) begin
      maskQ  <= initMask;
      emptyQ <= (frameLen == '0);
    end else if (ctl.growMask) begin
      maskQ  <= {maskQ[WORD_W-2:0], 1'b1};
    end
  end

  // completion reporting
  always_ff @(posedge clk) begin
    if (!rstN) begin
      codeQ <= '0;
      doneQ <= 1'b0;
    end else begin
      doneQ <= ctl.setCode;
      if (ctl.setCode) begin
        unique case (ctl.codeSel)
          C_EMPTY:   codeQ <= CODE_EMPTY;
          C_MASKOVF: codeQ <= CODE_MASKOVF;
          default:   codeQ <= statusCode;
        endcase
      end
    end
  end

  // chunked tick timer: remainder first, then whole periods
  always_ff @(posedge clk) begin
    if (!rstN) begin
      timerQ   <= '0;
      periodsQ <= '0;
    end else if (ctl.loadGap) begin
      timerQ   <= TIMER_W'(GAP_TICKS);
      periodsQ <= '0;
    end else if (ctl.loadBackoff) begin
      timerQ   <= totalTicks[TIMER_W-1:0];
      periodsQ <= totalTicks[TOTAL_W-1:TIMER_W];
    end else if (ctl.reloadPeriod) begin
      timerQ   <= '1;
      periodsQ <= periodsQ - 1'b1;
    end else if (tickStb && timerQ != '0) begin
      timerQ   <= timerQ - 1'b1;
    end
  end

  // R3
  mask_grow_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.growMask |=> maskQ[0] && maskQ[WORD_W-1:1] == $past(maskQ[WORD_W-2:0]));

  // R4
  ovf_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (doneQ && codeQ == CODE_MASKOVF) |-> $stable(maskQ));

  // R8
  timer_norise_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(ctl.loadGap || ctl.loadBackoff || ctl.reloadPeriod) |=> timerQ <= $past(timerQ));

  // R11
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |=> !doneQ);

endmodule

// File: rtl/tx_sched_ctl.sv
module tx_sched_ctl
  import txsched_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   startReq,
  input  logic   txStatusValid,
  input  logic   lenZero,
  input  logic   maskTop,
  input  logic   collOnly,
  input  logic   rndZero,
  input  logic   timerZero,
  input  logic   periodsZero,
  output dpCtl_t ctl,
  output logic   txEnable
);

  schedState_t stateQ, stateD;
  logic        pendQ, pendD;

  assign txEnable = (stateQ == S_TX);

  always_comb begin
    ctl    = '0;
    stateD = stateQ;
    pendD  = pendQ;
    unique case (stateQ)
      S_IDLE: begin
        if (startReq) begin
          ctl.loadDesc = 1'b1;
          stateD       = S_CHECK;
        end
      end
      S_CHECK: begin
        if (lenZero) begin
          ctl.setCode = 1'b1;
          ctl.codeSel = C_EMPTY;
          ctl.loadGap = 1'b1;
          stateD      = S_GAP;
        end else if (maskTop) begin
          ctl.setCode = 1'b1;
          ctl.codeSel = C_MASKOVF;
          ctl.loadGap = 1'b1;
          stateD      = S_GAP;
        end else begin
          ctl.growMask = 1'b1;
          stateD       = S_TX;
        end
      end
      S_TX: begin
        if (txStatusValid) begin
          if (collOnly) begin
            if (rndZero) begin
              stateD = S_CHECK;
            end else begin
              ctl.loadBackoff = 1'b1;
              stateD          = S_WAIT;
            end
          end else begin
            ctl.setCode = 1'b1;
            ctl.codeSel = C_STATUS;
            ctl.loadGap = 1'b1;
            stateD      = S_GAP;
          end
        end
      end
      S_WAIT: begin
        if (timerZero) begin
          if (periodsZero) stateD = S_CHECK;
          else             ctl.reloadPeriod = 1'b1;
        end
      end
      S_GAP: begin
        if (startReq && !pendQ) begin
          ctl.loadDesc = 1'b1;
          pendD        = 1'b1;
        end
        if (timerZero) begin
          stateD = (pendQ || startReq) ? S_CHECK : S_IDLE;
          pendD  = 1'b0;
        end
      end
      default: stateD = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= S_IDLE;
      pendQ  <= 1'b0;
    end else begin
      stateQ <= stateD;
      pendQ  <= pendD;
    end
  end

  // R8
  timer_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.loadGap, ctl.loadBackoff, ctl.reloadPeriod}));

  // R9
  gap_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.setCode |=> stateQ == S_GAP);

  // R10
  status_ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ != S_TX && stateQ != S_CHECK) |=> !$rose(txEnable));

endmodule

// File: rtl/tx_retry_sched.sv
module tx_retry_sched
  import txsched_pkg::*;
#(
  parameter int LEN_W     = 16,
  parameter int CHAN_ID   = 5,
  parameter int TIMER_W   = 7,
  parameter int TICK_MULT = 6,
  parameter int GAP_TICKS = 78
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic [LEN_W-1:0]  frameLen,
  input  logic [15:0]       initMask,
  input  logic [15:0]       txStatus,
  input  logic              txStatusValid,
  input  logic [15:0]       freeClock,
  input  logic              tickStb,
  output logic              txEnable,
  output logic [15:0]       maskOut,
  output logic [15:0]       complCode,
  output logic              donePulse
);

  dpCtl_t ctl;
  logic   lenZero, maskTop, collOnly, rndZero, timerZero, periodsZero;

  tx_sched_ctl u_ctl (
    .clk          (clk),
    .rstN         (rstN),
    .startReq     (startReq),
    .txStatusValid(txStatusValid),
    .lenZero      (lenZero),
    .maskTop      (maskTop),
    .collOnly     (collOnly),
    .rndZero      (rndZero),
    .timerZero    (timerZero),
    .periodsZero  (periodsZero),
    .ctl          (ctl),
    .txEnable     (txEnable)
  );

  tx_sched_dp #(
    .LEN_W    (LEN_W),
    .CHAN_ID  (CHAN_ID),
    .TIMER_W  (TIMER_W),
    .TICK_MULT(TICK_MULT),
    .GAP_TICKS(GAP_TICKS)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .frameLen   (frameLen),
    .initMask   (initMask),
    .txStatus   (txStatus),
    .freeClock  (freeClock),
    .tickStb    (tickStb),
    .lenZero    (lenZero),
    .maskTop    (maskTop),
    .collOnly   (collOnly),
    .rndZero    (rndZero),
    .timerZero  (timerZero),
    .periodsZero(periodsZero),
    .maskOut    (maskOut),
    .complCode  (complCode),
    .donePulse  (donePulse)
  );

endmodule

// File: tb/tx_retry_sched_test.sv
`timescale 1ns/1ps
module tx_retry_sched_test;

  localparam int CHAN = 5;
  localparam int GAP  = 78;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startReq = 1'b0;
  logic [15:0] frameLen = '0;
  logic [15:0] initMask = '0;
  logic [15:0] txStatus = '0;
  logic        txStatusValid = 1'b0;
  logic [15:0] freeClock = '0;
  logic        tickStb = 1'b0;
  logic        txEnable, donePulse;
  logic [15:0] maskOut, complCode;

  int checks = 0;
  int errors = 0;
  int doneCnt = 0;
  int txCnt = 0;

  always #2.5 clk = ~clk;

  tx_retry_sched #(.CHAN_ID(CHAN), .GAP_TICKS(GAP)) uut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .frameLen(frameLen),
    .initMask(initMask), .txStatus(txStatus), .txStatusValid(txStatusValid),
    .freeClock(freeClock), .tickStb(tickStb), .txEnable(txEnable),
    .maskOut(maskOut), .complCode(complCode), .donePulse(donePulse)
  );

  always @(negedge clk) begin
    if (donePulse) doneCnt++;
    if (txEnable)  txCnt++;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tickN(input int n);
    for (int i = 0; i < n; i++) begin
      tickStb = 1'b1;
      @(negedge clk);
      tickStb = 1'b0;
      cyc(3);
    end
  endtask

  task automatic startFrame(input logic [15:0] len, input logic [15:0] msk);
    frameLen = len; initMask = msk; startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
  endtask

  task automatic sendStatus(input logic [15:0] st);
    txStatus = st; txStatusValid = 1'b1;
    @(negedge clk);
    txStatusValid = 1'b0;
  endtask

  function automatic int expRnd(input logic [15:0] fc, input logic [15:0] msk);
    return int'(((fc >> 2) ^ 16'(CHAN)) & (msk >> 1));
  endfunction

  function automatic int expTicks(input int r);
    int t = 6 * r;
    return (t % 128) + 127 * (t / 128);
  endfunction

  task automatic t_reset;
    check(txEnable == 0 && donePulse == 0, "R1 outputs idle", {txEnable, donePulse}, 0);
    check(complCode == 0, "R1 code", complCode, 0);
    check(maskOut == 0, "R1 mask", maskOut, 0);
  endtask

  task automatic t_strayStatus;
    int d0 = doneCnt;
    sendStatus(16'h1000);
    cyc(3);
    check(doneCnt == d0 && complCode == 0, "R10 status outside tx ignored", doneCnt - d0, 0);
    check(txEnable == 0, "R10 no tx from stray status", txEnable, 0);
  endtask

  task automatic t_zeroLen;
    int d0 = doneCnt;
    int x0 = txCnt;
    startFrame(16'd0, 16'h0001);
    cyc(3);
    check(complCode == 16'h6800, "R2 empty code", complCode, 16'h6800);
    check(doneCnt == d0 + 1 && txCnt == x0, "R2 done without tx", txCnt - x0, 0);
  endtask

  task automatic t_gapHeld;
    // request queued during the gap left by the previous frame
    startFrame(16'd5, 16'h0003);
    tickN(GAP - 1);
    cyc(3);
    check(txEnable == 0, "R9 gap one tick short", txEnable, 0);
    tickN(1);
    check(txEnable == 1, "R9 queued start after gap", txEnable, 1);
    check(maskOut == 16'h0007, "R3 mask grown", maskOut, 16'h0007);
  endtask

  task automatic t_good;
    sendStatus(16'h8901);
    check(donePulse == 1 && complCode == 16'h4000, "R5 unexamined bits give good", complCode, 16'h4000);
    cyc(1);
    check(donePulse == 0, "R11 single done", donePulse, 0);
    check(complCode == 16'h4000, "R11 code held", complCode, 16'h4000);
    tickN(GAP);
  endtask

  task automatic t_err(input logic [15:0] st, input logic [15:0] exp);
    startFrame(16'd3, 16'h0000);
    cyc(3);
    check(txEnable == 1 && maskOut == 16'h0001, "R3 first attempt mask", maskOut, 1);
    sendStatus(st);
    check(complCode == exp, "R6 error code", complCode, exp);
    tickN(GAP);
  endtask

  task automatic t_retries;
    int r, n, d0;
    startFrame(16'd3, 16'h0000);
    cyc(3);
    d0 = doneCnt;
    freeClock = 16'h00FF;
    r = expRnd(freeClock, maskOut);
    sendStatus(16'h1000);
    cyc(3);
    check(r == 0 && txEnable == 1, "R7 zero random retries at once", txEnable, 1);
    check(maskOut == 16'h0003, "R7 mask grown on retry", maskOut, 3);
    freeClock = 16'd16;
    r = expRnd(freeClock, maskOut);
    n = expTicks(r);
    sendStatus(16'h1000);
    cyc(1);
    tickN(n - 1);
    check(txEnable == 0, "R8 short backoff not yet over", txEnable, 0);
    tickN(1);
    check(txEnable == 1 && n == 6, "R8 short backoff length", n, 6);
    check(maskOut == 16'h0007 && doneCnt == d0, "R7 retry keeps frame open", maskOut, 7);
    sendStatus(16'h0000);
    check(complCode == 16'h4000, "R5 clean status", complCode, 16'h4000);
    tickN(GAP);
  endtask

  task automatic t_longBackoff;
    int r, n;
    startFrame(16'd3, 16'h001F);
    cyc(3);
    check(maskOut == 16'h003F, "R3 grown preset mask", maskOut, 16'h003F);
    freeClock = 16'h0068;
    r = expRnd(freeClock, maskOut);
    n = expTicks(r);
    sendStatus(16'h1000);
    cyc(1);
    tickN(n - 1);
    check(txEnable == 0, "R8 long backoff one tick short", txEnable, 0);
    tickN(1);
    check(txEnable == 1 && n == 185, "R8 long backoff chunked", n, 185);
    check(maskOut == 16'h007F, "R3 mask after long backoff", maskOut, 16'h007F);
    sendStatus(16'h0000);
    tickN(GAP);
  endtask

  task automatic t_busyStart;
    int d0;
    startFrame(16'd3, 16'h0000);
    cyc(3);
    d0 = doneCnt;
    startFrame(16'd0, 16'h0001);
    cyc(2);
    check(txEnable == 1 && maskOut == 16'h0001, "R10 start during tx ignored", maskOut, 1);
    sendStatus(16'h0000);
    tickN(GAP);
    cyc(6);
    check(doneCnt == d0 + 1 && txEnable == 0, "R10 no extra frame served", doneCnt - d0, 1);
  endtask

  task automatic t_ovfInit;
    int x0 = txCnt;
    startFrame(16'd3, 16'h8001);
    cyc(3);
    check(complCode == 16'h6400, "R4 preset overflow code", complCode, 16'h6400);
    check(maskOut == 16'h8001 && txCnt == x0, "R4 mask kept no tx", maskOut, 16'h8001);
    tickN(GAP);
  endtask

  task automatic t_ovfGrow;
    startFrame(16'd3, 16'h4000);
    cyc(3);
    check(maskOut == 16'h8001 && txEnable == 1, "R3 mask reaches top", maskOut, 16'h8001);
    freeClock = 16'h0000;
    sendStatus(16'h1000);
    cyc(3);
    check(complCode == 16'h6400, "R4 grown overflow code", complCode, 16'h6400);
    check(maskOut == 16'h8001 && txEnable == 0, "R4 grown mask kept", maskOut, 16'h8001);
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog: actual 0x0 expected 0x1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    cyc(5);
    rstN = 1'b1;
    cyc(1);
    t_reset();
    t_strayStatus();
    t_zeroLen();
    t_gapHeld();
    t_good();
    t_err(16'h4200, 16'h7042);
    t_err(16'h1400, 16'h7014);
    t_retries();
    t_longBackoff();
    t_busyStart();
    t_ovfInit();
    t_ovfGrow();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule